// File: doc/BRIEF.md
# Pulse-Loaded 16:1 Serializer

This block turns a 16-bit parallel word into a serial bit stream that runs sixteen times faster than the word rate. Everything runs on the fast clock. The slow word clock enters as an ordinary input and is sampled on fast edges. A two-stage edge detector turns each rising word-clock edge into a load pulse one fast cycle wide. On that pulse, all sixteen shift stages take their bits from the selected parallel source at the same time. On every other fast edge the chain shifts one place toward bit 0. A final register after the chain drives the serial line.

The parallel source is chosen by a test-mode select. When it is high, the source is the pseudo-random pattern word. When it is low, the source is the external data word, which the surrounding chip ties to zero. A second select routes the serial stream to either the loopback line or the off-chip line. The line that is not selected stays at zero.

Top module: `ser16_pulse_load`

## Requirements
- R1: While reset is asserted, and afterwards until the first load has reached the output register, both serial outputs are 0.
- R2: A rising word-clock edge that is sampled high on fast edge k, after being sampled low on the edge before, loads the shift stages on fast edge k+1. The load happens once per rising edge, even when the word clock then stays high for many fast cycles.
- R3: Bit 0 of a loaded word reaches the serial output on fast edge k+2. Bits 1 to 15 follow on successive edges, one per edge, so bit 15 is last.
- R4: The next word may load on the same edge that bit 15 of the previous word reaches the output. With a word-clock period of 16 fast cycles, the stream then has no gap and no repeated bit.
- R5: When test mode is 1, the loaded word is the pattern word. When test mode is 0, the loaded word is the external word. The sources are sampled only on the load edge.
- R6: Changes on either parallel source or on test mode between load edges do not change the serial output.
- R7: When the loop select is 1, the loopback output carries the stream and the external output is 0. When the loop select is 0, the reverse holds. A change of loop select takes effect at once, without waiting for a fast edge.
- R8: Zeros enter the chain as it shifts. Without a new load, the output is 0 from the edge after bit 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_clk | input | 1 | Word-rate clock, sampled in the fast domain |
| test_mode | input | 1 | 1 selects the pattern word, 0 the external word |
| loop_sel | input | 1 | 1 routes the stream to loop_out, 0 to ext_out |
| prbs_word | input | W (16) | Pattern word |
| ext_word | input | W (16) | External data word |
| loop_out | output | 1 | Loopback serial line |
| ext_out | output | 1 | Off-chip serial line |

## Verification
The parallel load and the output register's capture of bit 15 from the previous word happen on the same fast edge whenever words are sent back to back. The bench provokes this by running the word clock continuously with a period of 16 fast cycles over walking-one, walking-zero and mixed words. It judges the result by comparing every output sample with the bit index that follows from the recorded rising edge: the last bit of one word must be followed at once by bit 0 of the next. The bench also toggles the loop select in the middle of a word and scrambles the sources on every non-load edge, so those events also coincide with shifting.

// File: rtl/ser16_pulse_load.sv
module ser16_pulse_load #(
  parameter int W = 16
) (
  input  logic         clk_fast,
  input  logic         rst_n,
  input  logic         word_clk,
  input  logic         test_mode,
  input  logic         loop_sel,
  input  logic [W-1:0] prbs_word,
  input  logic [W-1:0] ext_word,
  output logic         loop_out,
  output logic         ext_out
);

  logic         wc_q1, wc_q2;
  logic         load_pulse;
  logic [W-1:0] src_word;
  logic [W-1:0] shreg;
  logic         ser_q;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      wc_q1 <= 1'b0;
      wc_q2 <= 1'b0;
    end else begin
      wc_q1 <= word_clk;
      wc_q2 <= wc_q1;
    end
  end

  assign load_pulse = wc_q1 & ~wc_q2;
  assign src_word   = test_mode ? prbs_word : ext_word;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      ser_q <= 1'b0;
    end else begin
      shreg <= load_pulse ? src_word : {1'b0, shreg[W-1:1]};
      ser_q <= shreg[0];
    end
  end

  assign loop_out = loop_sel & ser_q;
  assign ext_out  = ~loop_sel & ser_q;

endmodule

module ser16_pulse_load_chk #(
  parameter int W = 16
) (
  input logic         clk_fast,
  input logic         rst_n,
  input logic         word_clk,
  input logic         test_mode,
  input logic         loop_sel,
  input logic [W-1:0] prbs_word,
  input logic [W-1:0] ext_word,
  input logic         load_pulse,
  input logic [W-1:0] shreg,
  input logic         loop_out,
  input logic         ext_out
);

  AST_LOAD_SINGLE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    load_pulse |=> !load_pulse); // R2

  AST_LOAD_AFTER_RISE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    ($past(word_clk) && !$past(word_clk, 2)) |-> load_pulse); // R2

  AST_LOAD_SOURCE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    load_pulse |=> (shreg == $past(test_mode ? prbs_word : ext_word))); // R5

  AST_EXT_QUIET: assert property (@(posedge clk_fast) disable iff (!rst_n)
    loop_sel |-> !ext_out); // R7

  AST_LOOP_QUIET: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !loop_sel |-> !loop_out); // R7

  AST_TAIL_ZERO: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !load_pulse |=> !shreg[W-1]); // R8

endmodule

bind ser16_pulse_load ser16_pulse_load_chk #(.W(W)) u_chk (
  .clk_fast(clk_fast), .rst_n(rst_n), .word_clk(word_clk),
  .test_mode(test_mode), .loop_sel(loop_sel), .prbs_word(prbs_word),
  .ext_word(ext_word), .load_pulse(load_pulse), .shreg(shreg),
  .loop_out(loop_out), .ext_out(ext_out)
);

// File: tb/ser16_pulse_load_tb.sv
module ser16_pulse_load_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_clk = 1'b0;
  logic        test_mode = 1'b1;
  logic        loop_sel = 1'b1;
  logic [15:0] prbs_word = '0;
  logic [15:0] ext_word = '0;
  logic        loop_out, ext_out;

  logic        rst_nx = 1'b0, wc_nx = 1'b0, tm_nx = 1'b1, ls_nx = 1'b1;
  logic [15:0] prbs_nx = '0, ext_nx = '0;

  int n = 0;
  int last_r = -1000, prev_r = -1000;
  logic [15:0] last_w = '0, prev_w = '0;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser16_pulse_load u_dut (
    .clk_fast(clk), .rst_n(rst_n), .word_clk(word_clk), .test_mode(test_mode),
    .loop_sel(loop_sel), .prbs_word(prbs_word), .ext_word(ext_word),
    .loop_out(loop_out), .ext_out(ext_out)
  );

  function automatic logic exp_bit();
    int r;
    int j;
    logic [15:0] w;
    if (n - 3 >= last_r) begin r = last_r; w = last_w; end
    else begin r = prev_r; w = prev_w; end
    j = n - 3 - r;
    if (j >= 0 && j <= 15) return w[j];
    return 1'b0;
  endfunction

  task automatic tick(input string tag);
    logic eb, el, ee;
    @(negedge clk);
    n++;
    eb = rst_n ? exp_bit() : 1'b0;
    el = loop_sel & eb;
    ee = ~loop_sel & eb;
    tests++;
    if (loop_out !== el) begin
      fails++;
      $display("FAIL %s loop_out n=%0d actual=%b expected=%b", tag, n, loop_out, el);
    end
    tests++;
    if (ext_out !== ee) begin
      fails++;
      $display("FAIL %s ext_out n=%0d actual=%b expected=%b", tag, n, ext_out, ee);
    end
    rst_n = rst_nx; test_mode = tm_nx; loop_sel = ls_nx;
    prbs_word = prbs_nx; ext_word = ext_nx;
    if (wc_nx && !word_clk && rst_n) begin
      prev_r = last_r; prev_w = last_w; last_r = n;
    end
    word_clk = wc_nx;
    if (n == last_r + 1) last_w = test_mode ? prbs_word : ext_word;
  endtask

  task automatic send(input logic [15:0] w, input logic tm, input logic flip, input string tag);
    tm_nx = tm;
    if (tm) begin prbs_nx = w; ext_nx = ~w; end
    else    begin ext_nx = w;  prbs_nx = ~w; end
    wc_nx = 1'b1;
    tick(tag);
    tick(tag);
    for (int i = 2; i < 16; i++) begin
      if (i == 8) wc_nx = 1'b0;
      prbs_nx = {prbs_nx[14:0], prbs_nx[15] ^ prbs_nx[12]} ^ 16'h3c96;
      ext_nx  = ext_nx + 16'h1357;
      if (i == 9) tm_nx = ~tm;
      if (flip && (i == 5 || i == 11)) ls_nx = ~ls_nx;
      tick(tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state, sources busy
    prbs_nx = 16'hffff; ext_nx = 16'hffff;
    repeat (4) tick("R1");
    rst_nx = 1'b1;
    repeat (6) tick("R1");

    // R3 R4 R6: back-to-back pattern words on loopback
    tm_nx = 1'b1; ls_nx = 1'b1;
    for (int i = 0; i < 16; i++) send(16'h0001 << i, 1'b1, 1'b0, "R3 R4 R6");
    for (int i = 0; i < 16; i++) send(~(16'h0001 << i), 1'b1, 1'b0, "R3 R4 R6");
    send(16'hffff, 1'b1, 1'b0, "R4");
    send(16'h0000, 1'b1, 1'b0, "R4");
    send(16'ha5c3, 1'b1, 1'b0, "R3");
    send(16'h8001, 1'b1, 1'b0, "R3");

    // R5 R7: external word on off-chip line
    ls_nx = 1'b0;
    for (int i = 0; i < 12; i++) send(16'(i * 16'h1357) ^ 16'h2468, 1'b0, 1'b0, "R5 R7");

    // R7: loop select toggled mid-word
    for (int i = 0; i < 6; i++) send(16'hc0de ^ 16'(i * 16'h0f0f), i[0], 1'b1, "R7");

    // R8: drain with word clock low
    wc_nx = 1'b0;
    for (int i = 0; i < 24; i++) begin
      prbs_nx = prbs_nx + 16'h0101;
      tick("R8 R6");
    end

    // R2: word clock held high loads once
    tm_nx = 1'b1; prbs_nx = 16'hb38d; ls_nx = 1'b1;
    wc_nx = 1'b1;
    tick("R2");
    tick("R2");
    for (int i = 0; i < 40; i++) begin
      prbs_nx = prbs_nx ^ 16'hffff;
      tick("R2 R8");
    end
    wc_nx = 1'b0;
    repeat (10) tick("R8");
    send(16'h7e81, 1'b1, 1'b0, "R2 R3");
    repeat (20) tick("R8");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule